// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial front end of a byte-wide nonvolatile memory with a 16-bit address space. A bus master lowers chip select and shifts in a one-byte command. Depending on the command, it then shifts in an address and data, or shifts out status, memory or identification bytes. The block uses SPI mode 0. Bits travel most significant first, the master's data is sampled on the rising serial clock, and returned data changes on the falling serial clock. The serial-out pin is driven only while a byte is actually being returned. A separate enable output tells the pad when to drive.

The block oversamples all serial pins with its own system clock and resynchronizes them. Storage is an internal register array of `2**MEM_AW` bytes. Only the low `MEM_AW` bits of the 16-bit address select a byte, so the upper bits alias. Every write to memory or status is gated by a write-enable latch. The latch clears itself once a write frame has finished, so each write frame must be preceded by its own enable frame.

Top module: `spimem_slave`

## Requirements
- R1: After reset the write-enable latch is clear, `spi_miso_oe` is low, and a status read returns 0x00.
- R2: Command, address and data bytes are shifted most significant bit first. Input is sampled on rising SCK and output changes on falling SCK, while chip select is low.
- R3: `spi_miso_oe` is high during every bit of a returned byte. It is low during command, address and dummy bytes, during written bytes, and while chip select is high.
- R4: Command 0x06 sets the write-enable latch, which reads back as bit 1 of the status byte.
- R5: Memory writes (0x02) and status writes (0x01) change nothing while the latch is clear.
- R6: Command 0x04 clears the write-enable latch.
- R7: When chip select rises after a memory or status write that received at least one full data byte with the latch set, the latch clears. Data written to the status register never sets or clears bit 1.
- R8: Read (0x03) takes a 16-bit address, high byte first, and then returns consecutive bytes. The address increments after each byte and wraps from 0xFFFF to 0x0000. Storage is selected by the low `MEM_AW` address bits.
- R9: Write (0x02) takes a 16-bit address and stores each full data byte at an incrementing address. A trailing partial byte is discarded. A frame that ends before its first full data byte writes nothing and leaves the latch set.
- R10: Fast read (0x0B) is like read, except that one dummy byte follows the address before data is returned.
- R11: Status read (0x05) returns exactly one byte, and further bytes in that frame are not driven. Status write stores only bits 7, 3 and 2, and all other bits read as 0.
- R12: Command 0x9F returns the repeating sequence 0x4D, 0x10, 0x2A, 0xE1. Command 0xC3 returns the repeating sequence 0x00, 0x5E, 0x91, 0x3B.
- R13: After command 0xB9 the block sleeps. The frame that begins with the next falling chip select wakes it and is ignored entirely. Later frames work normally.
- R14: Any other command byte is ignored for the rest of its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Drive enable for spi_miso; low means high impedance |

## Verification
A serial-pin edge reaches the internal logic through two synchronizer stages and an edge detector. A received byte is therefore acted on about three system clocks after its eighth rising SCK. The next output byte is loaded one clock later, and the falling SCK that follows puts a new bit on `spi_miso` about three clocks after that falling edge. The bench holds each SCK half period for eight system clocks. It samples `spi_miso` and `spi_miso_oe` on the last clock of each low phase, just before it raises SCK, which is well after every one of these latencies. A latch clear that depends on chip select rising is observed in the next frame, which starts several half periods later.

// File: rtl/spimem_pkg.sv
// Package: command codes, controller phases and the constant reply bytes
// shared by the serial memory slave modules.
package spimem_pkg;

    localparam int ADDR_W = 16;

    localparam logic [7:0] CMD_WEN_SET  = 8'h06;
    localparam logic [7:0] CMD_WEN_CLR  = 8'h04;
    localparam logic [7:0] CMD_STAT_GET = 8'h05;
    localparam logic [7:0] CMD_STAT_PUT = 8'h01;
    localparam logic [7:0] CMD_MEM_GET  = 8'h03;
    localparam logic [7:0] CMD_MEM_FAST = 8'h0B;
    localparam logic [7:0] CMD_MEM_PUT  = 8'h02;
    localparam logic [7:0] CMD_DOZE     = 8'hB9;
    localparam logic [7:0] CMD_IDENT    = 8'h9F;
    localparam logic [7:0] CMD_SERIAL   = 8'hC3;

    // Status bits that a status write may change; bit 1 mirrors the latch.
    localparam logic [7:0] STAT_KEEP_MASK = 8'b1000_1100;
    localparam int         WEN_BIT        = 1;

    typedef enum logic [3:0] {
        PH_CMD,
        PH_ADR_HI,
        PH_ADR_LO,
        PH_PAD,
        PH_RD,
        PH_WR,
        PH_STAT_OUT,
        PH_STAT_IN,
        PH_CONST,
        PH_IDLE
    } phase_t;

    // Returns one byte of a fixed 4-byte reply sequence.
    function automatic logic [7:0] const_reply(input logic serial_sel, input logic [1:0] idx);
        logic [7:0] b;
        if (serial_sel) begin
            case (idx)
                2'd0:    b = 8'h00;
                2'd1:    b = 8'h5E;
                2'd2:    b = 8'h91;
                default: b = 8'h3B;
            endcase
        end else begin
            case (idx)
                2'd0:    b = 8'h4D;
                2'd1:    b = 8'h10;
                2'd2:    b = 8'h2A;
                default: b = 8'hE1;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/spimem_front.sv
// Serial front end: synchronizes the SPI pins to clk, detects SCK and
// chip-select edges, assembles received words and shifts reply words out.
// Assumes each SCK half period lasts at least six clk cycles.
module spimem_front #(
    parameter int W      = 8,
    parameter int SYNC_N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         spi_csn,
    input  logic         spi_sck,
    input  logic         spi_mosi,
    input  logic         tx_load,
    input  logic [W-1:0] tx_word,
    output logic         cs_active,
    output logic         frame_start,
    output logic         frame_end,
    output logic         byte_valid,
    output logic [W-1:0] rx_word,
    output logic         miso_bit
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

    logic [SYNC_N-1:0] csn_sh, sck_sh, mosi_sh;
    logic              csn_q, sck_q;
    logic              csn_now, sck_now, mosi_now;
    logic              sck_rise, sck_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [W-1:0]      rx_sh, tx_sh;

    // Purpose: synchronizer chains for the three serial inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_sh  <= '1;
            sck_sh  <= '0;
            mosi_sh <= '0;
        end else begin
            csn_sh  <= {csn_sh[SYNC_N-2:0], spi_csn};
            sck_sh  <= {sck_sh[SYNC_N-2:0], spi_sck};
            mosi_sh <= {mosi_sh[SYNC_N-2:0], spi_mosi};
        end
    end

    assign csn_now  = csn_sh[SYNC_N-1];
    assign sck_now  = sck_sh[SYNC_N-1];
    assign mosi_now = mosi_sh[SYNC_N-1];

    // Purpose: previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_q <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            csn_q <= csn_now;
            sck_q <= sck_now;
        end
    end

    assign cs_active   = !csn_now;
    assign frame_start = csn_q && !csn_now;
    assign frame_end   = !csn_q && csn_now;
    assign sck_rise    = cs_active && sck_now && !sck_q;
    assign sck_fall    = cs_active && !sck_now && sck_q;

    // Purpose: bit counter and receive shift register, rising SCK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
        end else if (!cs_active) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            rx_sh   <= {rx_sh[W-2:0], mosi_now};
            bit_cnt <= (bit_cnt == CNT_W'(W-1)) ? '0 : bit_cnt + 1'b1;
        end
    end

    assign byte_valid = sck_rise && (bit_cnt == CNT_W'(W-1));
    assign rx_word    = {rx_sh[W-2:0], mosi_now};

    // Purpose: transmit shift register, loaded by the controller, shifted on falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh    <= '0;
            miso_bit <= 1'b0;
        end else if (tx_load) begin
            tx_sh <= tx_word;
        end else if (sck_fall) begin
            miso_bit <= tx_sh[W-1];
            tx_sh    <= {tx_sh[W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spimem_array.sv
// Byte storage: one write port and one combinational read port.
// Assumes write and read addresses are already reduced to AW bits.
module spimem_array #(
    parameter int AW = 10,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];

    // Purpose: store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spimem_ctrl.sv
// Command controller: decodes the command byte, tracks the address phase,
// owns the write-enable latch, status bits and sleep state, and chooses the
// next reply byte. Assumes byte_valid never coincides with frame edges.
module spimem_ctrl
    import spimem_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_active,
    input  logic          frame_start,
    input  logic          frame_end,
    input  logic          byte_valid,
    input  logic [7:0]    rx_word,
    input  logic [7:0]    mem_rdata,
    output logic          tx_load,
    output logic [7:0]    tx_word,
    output logic          miso_oe,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [7:0]    mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic          wel,
    output logic          sleeping
);
    phase_t        phase;
    logic [7:0]    cmd;
    logic [7:0]    adr_hi;
    logic [AW-1:0] addr;
    logic [7:0]    stat_bits;
    logic [7:0]    status_byte;
    logic          wrote;
    logic [1:0]    cidx;
    logic          is_serial;

    // Purpose: status byte as seen by the master.
    always_comb begin
        status_byte          = stat_bits & STAT_KEEP_MASK;
        status_byte[WEN_BIT] = wel;
    end

    // Purpose: read address for the byte to be loaded next.
    always_comb begin
        if (phase == PH_ADR_LO) begin
            mem_raddr = AW'({adr_hi, rx_word});
        end else if (phase == PH_PAD) begin
            mem_raddr = addr;
        end else begin
            mem_raddr = addr + 1'b1;
        end
    end

    assign is_serial = (cmd == CMD_SERIAL);
    assign mem_we    = cs_active && byte_valid && (phase == PH_WR) && wel;
    assign mem_waddr = addr;
    assign mem_wdata = rx_word;

    // Purpose: command phase machine, latch, status and reply selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CMD;
            cmd       <= '0;
            adr_hi    <= '0;
            addr      <= '0;
            stat_bits <= '0;
            wel       <= 1'b0;
            sleeping  <= 1'b0;
            wrote     <= 1'b0;
            cidx      <= '0;
            tx_word   <= '0;
            tx_load   <= 1'b0;
            miso_oe   <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            if (frame_start) begin
                phase    <= sleeping ? PH_IDLE : PH_CMD;
                sleeping <= 1'b0;
                wrote    <= 1'b0;
                miso_oe  <= 1'b0;
            end else if (frame_end) begin
                phase   <= PH_CMD;
                miso_oe <= 1'b0;
                wrote   <= 1'b0;
                if (wrote) begin
                    wel <= 1'b0;
                end
            end else if (byte_valid) begin
                case (phase)
                    PH_CMD: begin
                        cmd <= rx_word;
                        case (rx_word)
                            CMD_WEN_SET: begin
                                wel   <= 1'b1;
                                phase <= PH_IDLE;
                            end
                            CMD_WEN_CLR: begin
                                wel   <= 1'b0;
                                phase <= PH_IDLE;
                            end
                            CMD_STAT_GET: begin
                                tx_word <= status_byte;
                                tx_load <= 1'b1;
                                miso_oe <= 1'b1;
                                phase   <= PH_STAT_OUT;
                            end
                            CMD_STAT_PUT: phase <= PH_STAT_IN;
                            CMD_MEM_GET, CMD_MEM_FAST, CMD_MEM_PUT: phase <= PH_ADR_HI;
                            CMD_DOZE: begin
                                sleeping <= 1'b1;
                                phase    <= PH_IDLE;
                            end
                            CMD_IDENT, CMD_SERIAL: begin
                                tx_word <= const_reply(rx_word == CMD_SERIAL, 2'd0);
                                cidx    <= 2'd1;
                                tx_load <= 1'b1;
                                miso_oe <= 1'b1;
                                phase   <= PH_CONST;
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                    PH_ADR_HI: begin
                        adr_hi <= rx_word;
                        phase  <= PH_ADR_LO;
                    end
                    PH_ADR_LO: begin
                        addr <= AW'({adr_hi, rx_word});
                        if (cmd == CMD_MEM_PUT) begin
                            phase <= PH_WR;
                        end else if (cmd == CMD_MEM_FAST) begin
                            phase <= PH_PAD;
                        end else begin
                            tx_word <= mem_rdata;
                            tx_load <= 1'b1;
                            miso_oe <= 1'b1;
                            phase   <= PH_RD;
                        end
                    end
                    PH_PAD: begin
                        tx_word <= mem_rdata;
                        tx_load <= 1'b1;
                        miso_oe <= 1'b1;
                        phase   <= PH_RD;
                    end
                    PH_RD: begin
                        addr    <= addr + 1'b1;
                        tx_word <= mem_rdata;
                        tx_load <= 1'b1;
                    end
                    PH_WR: begin
                        addr <= addr + 1'b1;
                        if (wel) begin
                            wrote <= 1'b1;
                        end
                    end
                    PH_STAT_OUT: begin
                        miso_oe <= 1'b0;
                        phase   <= PH_IDLE;
                    end
                    PH_STAT_IN: begin
                        if (wel) begin
                            stat_bits <= rx_word & STAT_KEEP_MASK;
                            wrote     <= 1'b1;
                        end
                        phase <= PH_IDLE;
                    end
                    PH_CONST: begin
                        tx_word <= const_reply(is_serial, cidx);
                        cidx    <= cidx + 2'd1;
                        tx_load <= 1'b1;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/spimem_slave.sv
// Top level of the SPI mode-0 serial memory slave. Connects the serial
// front end, the command controller and the byte storage.
// Assumes MEM_AW <= 16 and SCK half periods of at least six clk cycles.
module spimem_slave #(
    parameter int MEM_AW = 10,
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_csn,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int W = 8;

    logic              cs_active, frame_start, frame_end, byte_valid;
    logic [W-1:0]      rx_word, tx_word, mem_rdata, mem_wdata;
    logic              tx_load, mem_we, wel, sleeping;
    logic [MEM_AW-1:0] mem_waddr, mem_raddr;

    spimem_front #(.W(W), .SYNC_N(SYNC_N)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_csn     (spi_csn),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .tx_load     (tx_load),
        .tx_word     (tx_word),
        .cs_active   (cs_active),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .byte_valid  (byte_valid),
        .rx_word     (rx_word),
        .miso_bit    (spi_miso)
    );

    spimem_ctrl #(.AW(MEM_AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_active   (cs_active),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .byte_valid  (byte_valid),
        .rx_word     (rx_word),
        .mem_rdata   (mem_rdata),
        .tx_load     (tx_load),
        .tx_word     (tx_word),
        .miso_oe     (spi_miso_oe),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata),
        .mem_raddr   (mem_raddr),
        .wel         (wel),
        .sleeping    (sleeping)
    );

    spimem_array #(.AW(MEM_AW), .W(W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/spimem_slave_chk.sv
// Checker: protocol and latch properties of spimem_slave, bound to the top.
module spimem_slave_chk
    import spimem_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_active,
    input logic       byte_valid,
    input logic [7:0] rx_word,
    input logic       wel,
    input logic       miso_oe,
    input logic       mem_we,
    input logic       sleeping
);
    // R3
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !miso_oe);

    // R4
    wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> ($past(byte_valid) && ($past(rx_word) == CMD_WEN_SET)));

    // R5
    write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wel && cs_active));

    // R7
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> (($past(byte_valid) && ($past(rx_word) == CMD_WEN_CLR)) || !$past(cs_active)));

    // R13
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleeping |-> !mem_we);

endmodule

bind spimem_slave spimem_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_active  (cs_active),
    .byte_valid (byte_valid),
    .rx_word    (rx_word),
    .wel        (wel),
    .miso_oe    (spi_miso_oe),
    .mem_we     (mem_we),
    .sleeping   (sleeping)
);

// File: tb/spimem_slave_test.sv
module spimem_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int MEM_AW     = 10;
    localparam int DEPTH      = 1 << MEM_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, oe;

    int checks = 0;
    int fails  = 0;

    logic [7:0] txb [32];
    logic [7:0] rxb [32];
    logic       oe_all [32];
    logic       oe_any [32];

    logic [7:0] mem_m [DEPTH];
    logic       wel_m = 1'b0;
    logic [7:0] stat_m = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    spimem_slave #(.MEM_AW(MEM_AW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_csn     (csn),
        .spi_sck     (sck),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (oe)
    );

    function automatic logic [7:0] exp_status();
        logic [7:0] s;
        s = stat_m & 8'h8C;
        s[1] = wel_m;
        return s;
    endfunction

    function automatic logic [7:0] exp_const(input logic ser, input int i);
        logic [7:0] a [4];
        logic [7:0] b [4];
        a = '{8'h4D, 8'h10, 8'h2A, 8'hE1};
        b = '{8'h00, 8'h5E, 8'h91, 8'h3B};
        return ser ? b[i % 4] : a[i % 4];
    endfunction

    function automatic int idx_of(input logic [15:0] a);
        return int'(a[MEM_AW-1:0]);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_frame(input int n, input int extra_bits);
        csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            oe_all[k] = 1'b1;
            oe_any[k] = 1'b0;
            for (int i = 7; i >= 0; i--) begin
                sck = 1'b0;
                mosi = txb[k][i];
                repeat (HALF) @(negedge clk);
                rxb[k][i] = miso;
                if (oe) oe_any[k] = 1'b1; else oe_all[k] = 1'b0;
                sck = 1'b1;
                repeat (HALF) @(negedge clk);
            end
        end
        for (int i = 0; i < extra_bits; i++) begin
            sck = 1'b0;
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic one_cmd(input logic [7:0] op);
        txb[0] = op;
        do_frame(1, 0);
        if (op == 8'h06) wel_m = 1'b1;
        if (op == 8'h04) wel_m = 1'b0;
    endtask

    task automatic check_status(input string req);
        txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00;
        do_frame(3, 0);
        chk(req, rxb[1], exp_status());
        chk({req, " R3 oe during status byte"}, {7'b0, oe_all[1]}, 8'h01);
        chk({req, " R11 R3 oe off after one status byte"}, {7'b0, oe_any[2]}, 8'h00);
        chk({req, " R3 oe off during command"}, {7'b0, oe_any[0]}, 8'h00);
    endtask

    // Data to write must be in txb[3..3+n-1] before the call.
    task automatic mem_write(input logic [15:0] a, input int n, input int extra);
        txb[0] = 8'h02; txb[1] = a[15:8]; txb[2] = a[7:0];
        do_frame(3 + n, extra);
        if (wel_m && n > 0) begin
            for (int k = 0; k < n; k++) mem_m[idx_of(a + 16'(k))] = txb[3 + k];
            wel_m = 1'b0;
        end
        for (int k = 0; k < n; k++)
            chk("R3 oe off during written byte", {7'b0, oe_any[3 + k]}, 8'h00);
    endtask

    task automatic mem_read(input logic [15:0] a, input int n, input logic fast, input string req);
        int base;
        base = fast ? 4 : 3;
        txb[0] = fast ? 8'h0B : 8'h03; txb[1] = a[15:8]; txb[2] = a[7:0]; txb[3] = 8'h00;
        for (int k = 0; k < n; k++) txb[base + k] = 8'hFF;
        do_frame(base + n, 0);
        if (fast) chk("R10 R3 oe off during dummy byte", {7'b0, oe_any[3]}, 8'h00);
        chk("R3 oe off during address", {7'b0, oe_any[2]}, 8'h00);
        for (int k = 0; k < n; k++) begin
            chk(req, rxb[base + k], mem_m[idx_of(a + 16'(k))]);
            chk("R3 oe on during read data", {7'b0, oe_all[base + k]}, 8'h01);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        logic [15:0] a;
        int n;
        void'($urandom(32'd7321));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 oe after reset", {7'b0, oe}, 8'h00);
        check_status("R1 status after reset");

        // R4 / R6 latch set and clear
        one_cmd(8'h06);
        check_status("R4 latch set");
        one_cmd(8'h04);
        check_status("R6 latch cleared");

        // R9 / R7 write then auto clear
        one_cmd(8'h06);
        txb[3] = 8'h55; txb[4] = 8'h77; txb[5] = 8'h99;
        mem_write(16'h0100, 3, 0);
        check_status("R7 latch clear after write");
        mem_read(16'h0100, 3, 1'b0, "R8 R2 read back");

        // R5 write without latch
        txb[3] = 8'hAA;
        mem_write(16'h0100, 1, 0);
        mem_read(16'h0100, 1, 1'b0, "R5 ignored write");

        // R9 partial trailing byte discarded
        one_cmd(8'h06);
        txb[3] = 8'h11; txb[4] = 8'h22;
        mem_write(16'h0100, 2, 4);
        mem_read(16'h0100, 3, 1'b0, "R9 partial byte discarded");
        check_status("R7 latch clear after partial tail");

        // R9 early abort keeps the latch
        one_cmd(8'h06);
        txb[0] = 8'h02; txb[1] = 8'h01;
        do_frame(2, 3);
        check_status("R9 abort leaves latch set");
        one_cmd(8'h04);

        // R8 wrap at 0xFFFF
        one_cmd(8'h06);
        txb[3] = 8'hC1; txb[4] = 8'hC2; txb[5] = 8'hC3;
        mem_write(16'hFFFE, 3, 0);
        mem_read(16'hFFFE, 3, 1'b0, "R8 wrap read");
        mem_read(16'h0000, 1, 1'b0, "R8 wrapped byte at 0x0000");

        // R10 fast read
        mem_read(16'h0101, 2, 1'b1, "R10 fast read");

        // R11 / R7 status write
        one_cmd(8'h06);
        txb[0] = 8'h01; txb[1] = 8'hFF; do_frame(2, 0);
        stat_m = 8'hFF; wel_m = 1'b0;
        check_status("R11 R7 status write masked");
        txb[0] = 8'h01; txb[1] = 8'h00; do_frame(2, 0);
        check_status("R5 status write without latch");
        one_cmd(8'h06);
        txb[0] = 8'h01; txb[1] = 8'h02; do_frame(2, 0);
        stat_m = 8'h02; wel_m = 1'b0;
        check_status("R7 status data cannot set latch bit");

        // R12 constant sequences
        for (int s = 0; s < 2; s++) begin
            txb[0] = (s == 1) ? 8'hC3 : 8'h9F;
            for (int k = 1; k <= 6; k++) txb[k] = 8'h00;
            do_frame(7, 0);
            for (int k = 0; k < 6; k++) begin
                chk("R12 constant reply", rxb[k + 1], exp_const(s == 1, k));
                chk("R12 R3 oe on during reply", {7'b0, oe_all[k + 1]}, 8'h01);
            end
        end

        // R14 unknown command
        one_cmd(8'h06);
        txb[0] = 8'h5A; txb[1] = 8'h00; txb[2] = 8'h00; do_frame(3, 0);
        chk("R14 unknown command drives nothing", {7'b0, oe_any[1] | oe_any[2]}, 8'h00);
        check_status("R14 latch unchanged by unknown command");
        one_cmd(8'h04);

        // R13 sleep and wake frame
        one_cmd(8'hB9);
        txb[0] = 8'h06; do_frame(1, 0);
        check_status("R13 wake frame ignored");
        one_cmd(8'hB9);
        txb[0] = 8'h05; txb[1] = 8'h00; do_frame(2, 0);
        chk("R13 no reply in wake frame", {7'b0, oe_any[1]}, 8'h00);
        check_status("R13 normal after wake");

        // Random bursts
        for (int it = 0; it < 24; it++) begin
            a = 16'($urandom);
            n = 1 + int'($urandom % 5);
            for (int k = 0; k < n; k++) txb[3 + k] = 8'($urandom);
            one_cmd(8'h06);
            mem_write(a, n, 0);
            mem_read(a, n, ($urandom % 2) == 1, "R2 R8 R9 random burst");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule